// File: doc/BRIEF.md
# SPI Transaction Phase Sequencer

This block is the master side of an SPI link. It runs one transaction as a fixed chain of optional phases: prepare, command, address, dummy, write-data and read-data, followed by a closing done phase. A start strobe launches the chain. Each phase is individually enabled and has its own bit count. Phases that are not enabled are skipped without costing any time. Command, address and write data are shifted out on MOSI. Read data is collected into a parallel word, either from MISO or, in 3-wire mode, from the shared data pin.

Configuration inputs set how the transaction runs. They choose the bit order for each direction, full-duplex or 3-wire half-duplex pin use, chip-select timing, whether SCLK is gated off during dummy cycles, and which phases an external hold line may pause and at what polarity. SCLK is the system clock divided by a programmable factor. The block works in SPI mode 0. All configuration, length and data inputs must stay stable from start until done.

Top module: `spi_phase_seq`

## Requirements
- R1: Phases run in the order prepare, command, address, dummy, write-data, read-data, done. `phase_en` bit 0 enables command, bit 1 address, bit 2 dummy, bit 3 write-data and bit 4 read-data. A disabled phase produces no SCLK pulses and takes no time. Each `len_*` input holds the phase's bit count minus one.
- R2: One bit time is 2*(`clk_div`+1) clocks. Prepare, dummy and done each last their bit count in bit times, and done is always one bit time. `done` is high for exactly one clock. It is first visible in the clock that follows edge 2*(`clk_div`+1)*B, counted from the edge that accepts `start`, where B is the total number of bit times of all phases that run.
- R3: Mode 0: MOSI changes only while SCLK is low, and it is valid at every SCLK rising edge. When `tx_msb_first`=1, each outgoing field (command, address, write data) sends bit `len` first and bit 0 last. When `tx_msb_first`=0, it sends bit 0 first.
- R4: The read phase samples its data line on each SCLK rising edge. Bit k of that phase (k counted from 0) lands in `rdata` at position `len_rd`-k when `rx_msb_first`=1, and at position k when it is 0. `rdata` clears to zero on start.
- R5: With `full_duplex`=1 and `three_wire`=0, the write-data phase also samples MISO on each rising edge. Bit k goes to `rdata` at position `len_wr`-k when `rx_msb_first`=1, and at position k otherwise.
- R6: With `three_wire`=1, read samples come from `sio_in`, and MISO is ignored. `mosi_oe` is low only during the read phase and is high everywhere else. MOSI is 0 whenever `mosi_oe` is low.
- R7: With `dummy_sclk_off`=1, SCLK stays low through the dummy phase. The dummy phase still takes its full length.
- R8: The prepare phase runs only when `cs_setup`=1, and it lasts `len_prep`+1 bit times with SCLK low. `cs_n` is low from the first phase that runs onward, and it is low at every SCLK rising edge.
- R9: In the done phase, `cs_n` is low if `cs_keep`=1 and high otherwise. When the sequencer is idle, which includes the clock in which `done` is high, `cs_n` is high.
- R10: Hold is active when `hold_in` equals `hold_pol`. When the levels differ, hold has no effect on timing.
- R11: `hold_en` bits 0 to 5 let hold stall prepare, command, address, dummy, write-data and read-data respectively. The stall starts at the next bit boundary. During a stall SCLK stays low and no bit advances. Hold has no effect in a state whose `hold_en` bit is 0.
- R12: A `start` pulse that arrives while a transaction is running is ignored.
- R13: During and after reset the outputs are `cs_n`=1, `sclk`=0, `mosi`=0, `mosi_oe`=1, `done`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, accepted when idle |
| phase_en | input | 5 | Enables for command, address, dummy, write-data and read-data |
| cs_setup | input | 1 | Run the prepare phase with chip select active |
| cs_keep | input | 1 | Keep chip select low through done |
| dummy_sclk_off | input | 1 | Gate SCLK during dummy |
| tx_msb_first | input | 1 | Bit order for outgoing fields |
| rx_msb_first | input | 1 | Bit order for incoming data |
| three_wire | input | 1 | Shared data pin mode |
| full_duplex | input | 1 | Sample MISO during write-data |
| hold_in | input | 1 | External hold line |
| hold_pol | input | 1 | Active level of hold_in |
| hold_en | input | 6 | Per-state hold enables |
| clk_div | input | DIV_W | SCLK half-period minus one, in clocks |
| len_prep | input | LEN_W | Prepare length minus one |
| len_cmd | input | LEN_W | Command bits minus one |
| len_addr | input | LEN_W | Address bits minus one |
| len_dummy | input | LEN_W | Dummy bits minus one |
| len_wr | input | LEN_W | Write-data bits minus one |
| len_rd | input | LEN_W | Read-data bits minus one |
| cmd | input | DW | Command value |
| addr | input | DW | Address value |
| wdata | input | DW | Write data |
| miso | input | 1 | Serial input in 4-wire mode |
| sio_in | input | 1 | Shared pin input in 3-wire mode |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output / shared pin drive value |
| mosi_oe | output | 1 | Drive enable for the data pin |
| cs_n | output | 1 | Chip select, active low |
| rdata | output | DW | Collected read data |
| done | output | 1 | One-clock completion pulse |

## Verification
Each SCLK rise lands on a divider tick. The bench samples on the falling clock edge right after it sees SCLK go high. MOSI, `mosi_oe` and `cs_n` are compared there against the bit that a model built from R1 and R3 predicts for that edge index. The next MISO or `sio_in` bit is driven in the same half-cycle, so it is settled well before the following rise. `done` is due exactly 2*(`clk_div`+1)*B clocks after the accepting edge. The bench counts falling edges from that point and compares the count, then checks one clock later that `done` has dropped and `cs_n` is high. `cs_n` in the done phase is sampled one clock before `done` appears. `rdata` is compared once the transaction ends, against a model the bench filled from the bits it drove.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PREP  = 3'd1,
    PH_CMD   = 3'd2,
    PH_ADDR  = 3'd3,
    PH_DUMMY = 3'd4,
    PH_WR    = 3'd5,
    PH_RD    = 3'd6,
    PH_DONE  = 3'd7
  } ph_e;

  // first enabled phase strictly after cur; after done comes idle
  function automatic ph_e ph_next(input ph_e cur, input logic [7:0] en);
    ph_e res;
    logic found;
    res   = PH_IDLE;
    found = 1'b0;
    for (int i = 1; i < 8; i++) begin
      if (!found && (i > int'(cur)) && en[i]) begin
        res   = ph_e'(3'(i));
        found = 1'b1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/spi_seq_tick.sv
module spi_seq_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_n;

  assign tick = run && (cnt_q == div);

  always_comb begin
    cnt_n = cnt_q;
    if (!run)      cnt_n = '0;
    else if (tick) cnt_n = '0;
    else           cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick); // R2

endmodule

// File: rtl/spi_seq_hold.sv
module spi_seq_hold
  import spi_seq_pkg::*;
(
  input  ph_e        phase,
  input  logic       hold_in,
  input  logic       hold_pol,
  input  logic [5:0] hold_en,
  output logic       stall
);

  logic       active;
  logic [2:0] ph;

  assign active = (hold_in == hold_pol);
  assign ph     = phase;

  always_comb begin
    stall = 1'b0;
    if (active && (ph >= 3'd1) && (ph <= 3'd6))
      stall = hold_en[ph - 3'd1];
  end

endmodule

// File: rtl/spi_phase_seq.sv
module spi_phase_seq
  import spi_seq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DIV_W = 8,
  localparam int LEN_W = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [4:0]       phase_en,
  input  logic             cs_setup,
  input  logic             cs_keep,
  input  logic             dummy_sclk_off,
  input  logic             tx_msb_first,
  input  logic             rx_msb_first,
  input  logic             three_wire,
  input  logic             full_duplex,
  input  logic             hold_in,
  input  logic             hold_pol,
  input  logic [5:0]       hold_en,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [LEN_W-1:0] len_prep,
  input  logic [LEN_W-1:0] len_cmd,
  input  logic [LEN_W-1:0] len_addr,
  input  logic [LEN_W-1:0] len_dummy,
  input  logic [LEN_W-1:0] len_wr,
  input  logic [LEN_W-1:0] len_rd,
  input  logic [DW-1:0]    cmd,
  input  logic [DW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             miso,
  input  logic             sio_in,
  output logic             sclk,
  output logic             mosi,
  output logic             mosi_oe,
  output logic             cs_n,
  output logic [DW-1:0]    rdata,
  output logic             done
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  ph_e              phase_q, phase_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic             hi_q, hi_n;
  logic [DW-1:0]    rdata_q, rdata_n;
  logic             done_q, done_n;

  logic             tick, stall, rise, fall, last;
  logic [7:0]       en_vec;
  logic [LEN_W-1:0] cur_len, tx_idx, rx_pos;
  logic [DW-1:0]    src;
  logic             out_ph, clk_on, sample_en, din;

  spi_seq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(srst_n),
    .run  (phase_q != PH_IDLE),
    .div  (clk_div),
    .tick (tick)
  );

  spi_seq_hold u_hold (
    .phase   (phase_q),
    .hold_in (hold_in),
    .hold_pol(hold_pol),
    .hold_en (hold_en),
    .stall   (stall)
  );

  assign en_vec = {1'b1, phase_en, cs_setup, 1'b0};

  always_comb begin
    unique case (phase_q)
      PH_PREP:  cur_len = len_prep;
      PH_CMD:   cur_len = len_cmd;
      PH_ADDR:  cur_len = len_addr;
      PH_DUMMY: cur_len = len_dummy;
      PH_WR:    cur_len = len_wr;
      PH_RD:    cur_len = len_rd;
      default:  cur_len = '0;
    endcase
  end

  always_comb begin
    unique case (phase_q)
      PH_CMD:  src = cmd;
      PH_ADDR: src = addr;
      PH_WR:   src = wdata;
      default: src = '0;
    endcase
  end

  assign out_ph    = (phase_q == PH_CMD) || (phase_q == PH_ADDR) || (phase_q == PH_WR);
  assign clk_on    = out_ph || (phase_q == PH_RD) ||
                     ((phase_q == PH_DUMMY) && !dummy_sclk_off);
  assign sample_en = (phase_q == PH_RD) ||
                     ((phase_q == PH_WR) && full_duplex && !three_wire);
  assign din       = three_wire ? sio_in : miso;

  assign tx_idx = tx_msb_first ? (cur_len - cnt_q) : cnt_q;
  assign rx_pos = rx_msb_first ? (cur_len - cnt_q) : cnt_q;
  assign last   = (cnt_q == cur_len);

  // rising half only at a bit boundary, and only when not held
  assign rise = tick && !hi_q && !stall;
  assign fall = tick && hi_q;

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    hi_n    = hi_q;
    rdata_n = rdata_q;
    done_n  = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (start) begin
        phase_n = ph_next(PH_IDLE, en_vec);
        cnt_n   = '0;
        hi_n    = 1'b0;
        rdata_n = '0;
      end
    end else begin
      if (rise) begin
        hi_n = 1'b1;
        if (sample_en) rdata_n[rx_pos] = din;
      end
      if (fall) begin
        hi_n = 1'b0;
        if (last) begin
          cnt_n   = '0;
          phase_n = ph_next(phase_q, en_vec);
          done_n  = (phase_q == PH_DONE);
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      hi_q    <= hi_n;
      rdata_q <= rdata_n;
      done_q  <= done_n;
    end
  end

  assign sclk    = hi_q && clk_on;
  assign mosi    = out_ph ? src[tx_idx] : 1'b0;
  assign mosi_oe = !(three_wire && (phase_q == PH_RD));
  assign cs_n    = (phase_q == PH_IDLE) || ((phase_q == PH_DONE) && !cs_keep);
  assign rdata   = rdata_q;
  assign done    = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> !done); // R2
  AST_DONE_CS_FREE: assert property (@(posedge clk) disable iff (!srst_n)
    done |-> cs_n); // R9
  AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!srst_n)
    (stall && !hi_q) |=> !sclk); // R11
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!srst_n)
    (stall && !hi_q) |=> $stable(cnt_q)); // R11
  AST_DUMMY_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    (phase_q == PH_DUMMY && dummy_sclk_off) |-> !sclk); // R7
  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    !mosi_oe |-> !mosi); // R6
  AST_MOSI_LOW_CHANGE: assert property (@(posedge clk) disable iff (!srst_n)
    (sclk && $past(sclk) && out_ph && $past(phase_q) == phase_q) |-> $stable(mosi)); // R3

endmodule

// File: tb/spi_phase_seq_bench.sv
module spi_phase_seq_bench;
  localparam int DW = 32;
  localparam int DIV_W = 8;
  localparam int LEN_W = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, start;
  logic [4:0]       phase_en;
  logic             cs_setup, cs_keep, dummy_sclk_off, tx_msb_first, rx_msb_first;
  logic             three_wire, full_duplex, hold_in, hold_pol;
  logic [5:0]       hold_en;
  logic [DIV_W-1:0] clk_div;
  logic [LEN_W-1:0] len_prep, len_cmd, len_addr, len_dummy, len_wr, len_rd;
  logic [DW-1:0]    cmd, addr, wdata;
  logic             miso, sio_in;
  logic             sclk, mosi, mosi_oe, cs_n, done;
  logic [DW-1:0]    rdata;

  spi_phase_seq u_spi_phase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .phase_en(phase_en),
    .cs_setup(cs_setup), .cs_keep(cs_keep), .dummy_sclk_off(dummy_sclk_off),
    .tx_msb_first(tx_msb_first), .rx_msb_first(rx_msb_first),
    .three_wire(three_wire), .full_duplex(full_duplex),
    .hold_in(hold_in), .hold_pol(hold_pol), .hold_en(hold_en), .clk_div(clk_div),
    .len_prep(len_prep), .len_cmd(len_cmd), .len_addr(len_addr),
    .len_dummy(len_dummy), .len_wr(len_wr), .len_rd(len_rd),
    .cmd(cmd), .addr(addr), .wdata(wdata), .miso(miso), .sio_in(sio_in),
    .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe), .cs_n(cs_n),
    .rdata(rdata), .done(done)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected per-edge behaviour
  bit       exp_mosi [256];
  bit       exp_samp [256];
  int       exp_pos  [256];
  bit       exp_oe   [256];
  int       n_exp;
  int       tot_bits;
  logic [63:0] pat_a, pat_b;

  // kind: 0 outgoing field, 1 dummy, 2 write-data, 3 read-data
  function automatic void add_bits(input int kind, input logic [DW-1:0] src, input int len);
    for (int k = 0; k <= len; k++) begin
      exp_mosi[n_exp] = 1'b0;
      exp_samp[n_exp] = 1'b0;
      exp_pos[n_exp]  = 0;
      exp_oe[n_exp]   = 1'b1;
      if (kind == 0 || kind == 2)
        exp_mosi[n_exp] = tx_msb_first ? src[len-k] : src[k];
      if (kind == 2) begin
        exp_samp[n_exp] = full_duplex && !three_wire;
        exp_pos[n_exp]  = rx_msb_first ? len - k : k;
      end
      if (kind == 3) begin
        exp_samp[n_exp] = 1'b1;
        exp_pos[n_exp]  = rx_msb_first ? len - k : k;
        exp_oe[n_exp]   = !three_wire;
      end
      n_exp++;
    end
  endfunction

  function automatic void build_exp();
    n_exp = 0;
    tot_bits = 1;
    if (cs_setup) tot_bits += int'(len_prep) + 1;
    if (phase_en[0]) begin add_bits(0, cmd, int'(len_cmd));     tot_bits += int'(len_cmd) + 1; end
    if (phase_en[1]) begin add_bits(0, addr, int'(len_addr));   tot_bits += int'(len_addr) + 1; end
    if (phase_en[2]) begin
      if (!dummy_sclk_off) add_bits(1, '0, int'(len_dummy));
      tot_bits += int'(len_dummy) + 1;
    end
    if (phase_en[3]) begin add_bits(2, wdata, int'(len_wr));    tot_bits += int'(len_wr) + 1; end
    if (phase_en[4]) begin add_bits(3, '0, int'(len_rd));       tot_bits += int'(len_rd) + 1; end
  endfunction

  // hold_mode: 0 none, 1 held at start then released, 2 wrong polarity, 3 held in unused state only
  task automatic run_txn(input int hold_mode, input bit restart);
    int          t_exp, edges, mism, oe_bad, cs_bad, n_done;
    bit          prev, cs_dph;
    logic [DW-1:0] model;
    build_exp();
    t_exp = 2 * (int'(clk_div) + 1) * tot_bits;
    case (hold_mode)
      1: begin hold_en = 6'h3f; hold_in = hold_pol; end
      2: begin hold_en = 6'h3f; hold_in = ~hold_pol; end
      3: begin hold_en = 6'b001000; hold_in = hold_pol; end
      default: begin hold_in = ~hold_pol; end
    endcase
    model = '0; edges = 0; mism = 0; oe_bad = 0; cs_bad = 0; n_done = -1;
    prev = 1'b0; cs_dph = 1'b0;
    miso = pat_a[0]; sio_in = pat_b[0];
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int n = 0; n < 20000; n++) begin
      if (n == 0) chk(cs_n == 1'b0, "R8", "cs_n after start", cs_n, 0);
      if (restart && n == 5) start = 1'b1;
      if (restart && n == 6) start = 1'b0;
      if (hold_mode == 1 && n == 29) chk(edges == 0, "R11", "edges while held", edges, 0);
      if (hold_mode == 1 && n == 30) hold_in = ~hold_pol;
      if (sclk && !prev) begin
        if (edges < n_exp) begin
          if (mosi !== exp_mosi[edges]) mism++;
          if (mosi_oe !== exp_oe[edges]) oe_bad++;
          if (exp_samp[edges])
            model[exp_pos[edges]] = three_wire ? pat_b[edges % 64] : pat_a[edges % 64];
        end
        if (cs_n !== 1'b0) cs_bad++;
        edges++;
      end
      prev = sclk;
      if (n == t_exp - 1) cs_dph = cs_n;
      if (done) begin
        n_done = n;
        @(negedge clk);
        chk(done == 1'b0, "R2", "done width", done, 0);
        chk(cs_n == 1'b1, "R9", "cs_n idle after done", cs_n, 1);
        break;
      end
      miso = pat_a[edges % 64];
      sio_in = pat_b[edges % 64];
      @(negedge clk);
    end
    chk(edges == n_exp, "R1/R7", "sclk rising edges", edges, n_exp);
    chk(mism == 0, "R3", "mosi bit mismatches", mism, 0);
    chk(cs_bad == 0, "R8", "cs_n high at sclk edge", cs_bad, 0);
    chk(oe_bad == 0, "R6", "mosi_oe mismatches", oe_bad, 0);
    chk(rdata == model, "R4/R5", "rdata", rdata, model);
    if (hold_mode == 1) begin
      chk(n_done > t_exp, "R11", "held duration", n_done, t_exp);
    end else begin
      chk(n_done == t_exp, restart ? "R12" : (hold_mode == 0 ? "R2" : "R10"), "done cycle", n_done, t_exp);
      chk(cs_dph == !cs_keep, "R9", "cs_n in done phase", cs_dph, !cs_keep);
    end
    hold_in = ~hold_pol;
    repeat (3) @(negedge clk);
  endtask

  task automatic base_cfg();
    phase_en = 5'b11111; cs_setup = 1'b1; cs_keep = 1'b0; dummy_sclk_off = 1'b0;
    tx_msb_first = 1'b1; rx_msb_first = 1'b1; three_wire = 1'b0; full_duplex = 1'b0;
    hold_pol = 1'b1; hold_in = 1'b0; hold_en = '0; clk_div = '0;
    len_prep = 5'd1; len_cmd = 5'd7; len_addr = 5'd15; len_dummy = 5'd3;
    len_wr = 5'd7; len_rd = 5'd7;
    cmd = 32'h0000_00A5; addr = 32'h0000_3C96; wdata = 32'h0000_005A;
    pat_a = 64'hF0E1_D2C3_B4A5_9687; pat_b = 64'h1357_9BDF_2468_ACE0;
  endtask

  task automatic rand_cfg();
    phase_en = 5'($urandom) | 5'b00001;
    cs_setup = 1'($urandom); cs_keep = 1'($urandom); dummy_sclk_off = 1'($urandom);
    tx_msb_first = 1'($urandom); rx_msb_first = 1'($urandom);
    three_wire = 1'($urandom); full_duplex = 1'($urandom);
    hold_pol = 1'($urandom); hold_en = 6'($urandom);
    clk_div = DIV_W'($urandom % 3);
    len_prep = 5'($urandom % 4); len_cmd = 5'($urandom % 16); len_addr = 5'($urandom % 32);
    len_dummy = 5'($urandom % 8); len_wr = 5'($urandom % 32); len_rd = 5'($urandom % 32);
    cmd = $urandom; addr = $urandom; wdata = $urandom;
    pat_a = {$urandom, $urandom}; pat_b = {$urandom, $urandom};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    base_cfg();
    start = 1'b0; miso = 1'b0; sio_in = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && done == 1'b0, "R13", "cs_n/sclk/done in reset",
        {cs_n, sclk, done}, 3'b100);
    chk(mosi == 1'b0 && mosi_oe == 1'b1 && rdata == '0, "R13", "mosi/oe/rdata in reset",
        {mosi, mosi_oe}, 2'b01);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // all phases, msb first, keep cs in done
    base_cfg(); cs_keep = 1'b1; run_txn(0, 1'b0);
    // lsb first, slower clock, no prepare
    base_cfg(); tx_msb_first = 1'b0; rx_msb_first = 1'b0; clk_div = 8'd2; cs_setup = 1'b0;
    run_txn(0, 1'b0);
    // dummy clock gated (R7)
    base_cfg(); dummy_sclk_off = 1'b1; len_dummy = 5'd9; run_txn(0, 1'b0);
    // full duplex write only (R5)
    base_cfg(); phase_en = 5'b01001; full_duplex = 1'b1; len_wr = 5'd31; wdata = 32'hC001_D00D;
    run_txn(0, 1'b0);
    // three-wire read (R6)
    base_cfg(); phase_en = 5'b10001; three_wire = 1'b1; len_rd = 5'd31; run_txn(0, 1'b0);
    // hold held from start, then released (R11)
    base_cfg(); clk_div = 8'd1; run_txn(1, 1'b0);
    base_cfg(); hold_pol = 1'b0; run_txn(1, 1'b0);
    // wrong polarity has no effect (R10)
    base_cfg(); hold_pol = 1'b0; run_txn(2, 1'b0);
    // held only in a state that never runs (R11)
    base_cfg(); phase_en = 5'b11011; run_txn(3, 1'b0);
    // start while busy (R12)
    base_cfg(); run_txn(0, 1'b1);

    for (int i = 0; i < 24; i++) begin
      rand_cfg();
      run_txn(0, 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule